// File: doc/BRIEF.md
# One-Time-Programmable Memory Programming Port

This block is the device-side logic of a programming port for a one-time-programmable program store. An external programmer never supplies an address. It selects an operation on a 4-bit mode bus and steps an internal word pointer by toggling a programming clock pin. Every group of four falling edges on that pin forms one word cycle. The pointer advances by one on the third falling edge of each group, and the 16-bit word moves over an 8-bit data path: the low byte first, then the high byte.

There are four operations: pointer clear, write, verify and program inhibit. Verify drives the byte selected at the current pointer and phase. Write merges the captured word into the cell. It can only turn ones into zeros, and it acts only while the `prog_en` input (which stands in for the programming supply) is high. Cells start erased at all ones. The bidirectional data pin is split into an input byte, an output byte and an output enable, which the pad ring combines. The system clock samples the programming clock and the mode bus. Programming-clock levels must therefore each last several system clocks.

Top module: `otp_prog_port`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `data_oe` is 0, `data_o` is 0, and the pointer and phase are 0.
- R2: The mode bus bit i is mode pin i. The code 4'b0101 selects clear, 4'b1110 selects write, 4'b1100 selects verify and 4'b1111 selects inhibit. Every other code behaves as inhibit.
- R3: While clear is selected, the pointer and the phase counter are held at 0, and falling edges of `pclk` have no effect.
- R4: Outside clear, each falling edge of `pclk` advances the phase counter modulo 4. The third falling edge of a cycle (phase 2 to 3) also advances the pointer by exactly one, in the write, verify and inhibit modes alike.
- R5: The pointer wraps from its last address (2^ADDR_W − 1) to 0.
- R6: In verify mode `data_oe` is 1. `data_o` carries bits 15:8 of the word at the pointer when the phase is 2, and bits 7:0 in phases 0, 1 and 3.
- R7: Outside verify mode `data_oe` is 0 and `data_o` is 0.
- R8: In write mode with `prog_en` high, `data_i` is captured as the low byte at the second falling edge of a cycle. At the third falling edge, `data_i` is taken as the high byte, and the cell at the pointer becomes its old value AND the new word.
- R9: A write cycle with `prog_en` low, and any cycle in inhibit mode or under an undefined code, leaves every cell unchanged.
- R10: Every cell that has never been written reads 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pclk | input | 1 | Programming clock; falling edges step the phase and pointer |
| md | input | 4 | Operation select, bit i is mode pin i |
| prog_en | input | 1 | Programming supply present; gates writes |
| data_i | input | 8 | Byte received from the data pin |
| data_o | output | 8 | Byte to drive onto the data pin in verify mode |
| data_oe | output | 1 | Drive enable for the data pin |

## Verification
On every cycle, assertions check that the pointer only ever steps by one or returns to zero, that it steps only on the phase 2 to 3 transition, that clear forces the pointer and phase to zero, that verify mode enables the drivers, and that the output byte is zero whenever the drivers are off. Some behaviour can only be shown by the bench's scenarios, where a behavioural model of the cells is compared on every settled clock: that the stored word is the AND of the old and new data, that writes are refused without `prog_en` or under inhibit and undefined codes, that a clear in mid-cycle realigns the phase, and that the pointer wraps after the last address.

// File: rtl/otp_pkg.sv
package otp_pkg;

  typedef enum logic [1:0] {
    OP_INHIBIT = 2'd0,
    OP_CLEAR   = 2'd1,
    OP_WRITE   = 2'd2,
    OP_VERIFY  = 2'd3
  } otp_op_e;

  localparam int PHASE_W = 2;
  localparam logic [3:0] CODE_CLEAR  = 4'b0101;
  localparam logic [3:0] CODE_WRITE  = 4'b1110;
  localparam logic [3:0] CODE_VERIFY = 4'b1100;

  localparam logic [PHASE_W-1:0] PH_LO_TAKE = 2'd1;
  localparam logic [PHASE_W-1:0] PH_COMMIT  = 2'd2;

  function automatic otp_op_e decode_mode(input logic [3:0] code);
    otp_op_e op;
    case (code)
      CODE_CLEAR:  op = OP_CLEAR;
      CODE_WRITE:  op = OP_WRITE;
      CODE_VERIFY: op = OP_VERIFY;
      default:     op = OP_INHIBIT;
    endcase
    return op;
  endfunction

endpackage

// File: rtl/otp_mode_dec.sv
module otp_mode_dec
  import otp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] md,
  output otp_op_e    op
);

  always_ff @(posedge clk) begin
    if (rst) op <= OP_INHIBIT;
    else     op <= decode_mode(md);
  end

endmodule

// File: rtl/otp_seq.sv
module otp_seq
  import otp_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pclk,
  input  otp_op_e             op,
  output logic [ADDR_W-1:0]   addr,
  output logic [PHASE_W-1:0]  phase,
  output logic                lo_take,
  output logic                commit
);

  logic pclk_s, pclk_d;
  logic fall, clr;

  assign fall    = pclk_d & ~pclk_s;
  assign clr     = (op == OP_CLEAR);
  assign lo_take = fall && !clr && (phase == PH_LO_TAKE);
  assign commit  = fall && !clr && (phase == PH_COMMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      pclk_s <= 1'b0;
      pclk_d <= 1'b0;
      addr   <= '0;
      phase  <= '0;
    end else begin
      pclk_s <= pclk;
      pclk_d <= pclk_s;
      if (clr) begin
        addr  <= '0;
        phase <= '0;
      end else if (fall) begin
        phase <= phase + 1'b1;
        if (phase == PH_COMMIT) addr <= addr + 1'b1;
      end
    end
  end

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (rst)
    (addr != $past(addr)) |-> (addr == $past(addr) + 1'b1 || addr == '0));

  assert_clear_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (op == OP_CLEAR) |=> (addr == '0 && phase == '0));

  assert_step_on_third_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(op) != OP_CLEAR && addr != $past(addr)) |->
      ($past(phase) == PH_COMMIT && phase == PH_COMMIT + 1'b1));

endmodule

// File: rtl/otp_array.sv
module otp_array
  import otp_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int WORD_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  otp_op_e             op,
  input  logic                prog_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [PHASE_W-1:0]  phase,
  input  logic                lo_take,
  input  logic                commit,
  input  logic [WORD_W/2-1:0] data_i,
  output logic [WORD_W/2-1:0] data_o,
  output logic                data_oe
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int BYTE_W = WORD_W / 2;

  logic [WORD_W-1:0] cells [DEPTH];
  logic [WORD_W-1:0] rd_q;
  logic [BYTE_W-1:0] lo_q;
  logic              wr_en;

  initial begin
    for (int i = 0; i < DEPTH; i++) cells[i] = '1;
  end

  assign wr_en = commit && (op == OP_WRITE) && prog_en;

  // Read-first array port; rd_q tracks the cell under the pointer
  always_ff @(posedge clk) begin
    if (wr_en) cells[addr] <= rd_q & {data_i, lo_q};
    rd_q <= cells[addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q    <= '1;
      data_o  <= '0;
      data_oe <= 1'b0;
    end else begin
      if (lo_take && op == OP_WRITE) lo_q <= data_i;
      data_oe <= (op == OP_VERIFY);
      if (op == OP_VERIFY)
        data_o <= (phase == PH_COMMIT) ? rd_q[WORD_W-1:BYTE_W] : rd_q[BYTE_W-1:0];
      else
        data_o <= '0;
    end
  end

  assert_quiet_when_off_R7: assert property (@(posedge clk) disable iff (rst)
    !data_oe |-> (data_o == '0));

  assert_verify_drives_R6: assert property (@(posedge clk) disable iff (rst)
    (op == OP_VERIFY) |=> data_oe);

endmodule

// File: rtl/otp_prog_port.sv
module otp_prog_port
  import otp_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int WORD_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pclk,
  input  logic [3:0]          md,
  input  logic                prog_en,
  input  logic [WORD_W/2-1:0] data_i,
  output logic [WORD_W/2-1:0] data_o,
  output logic                data_oe
);

  otp_op_e             op;
  logic [ADDR_W-1:0]   addr;
  logic [PHASE_W-1:0]  phase;
  logic                lo_take, commit;

  otp_mode_dec u_dec (
    .clk (clk), .rst (rst), .md (md), .op (op)
  );

  otp_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk (clk), .rst (rst), .pclk (pclk), .op (op),
    .addr (addr), .phase (phase), .lo_take (lo_take), .commit (commit)
  );

  otp_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_arr (
    .clk (clk), .rst (rst), .op (op), .prog_en (prog_en),
    .addr (addr), .phase (phase), .lo_take (lo_take), .commit (commit),
    .data_i (data_i), .data_o (data_o), .data_oe (data_oe)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!data_oe && data_o == '0));

endmodule

// File: tb/otp_prog_port_tb.sv
`timescale 1ns/1ps
module otp_prog_port_tb;

  localparam int ADDR_W = 11;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pclk = 1'b0;
  logic [3:0] md = 4'b1111;
  logic       prog_en = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic [7:0] data_o;
  logic       data_oe;

  always #2.5 clk = ~clk;

  otp_prog_port #(.ADDR_W(ADDR_W)) u_dut (
    .clk (clk), .rst (rst), .pclk (pclk), .md (md), .prog_en (prog_en),
    .data_i (data_i), .data_o (data_o), .data_oe (data_oe)
  );

  // behavioural reference: 0 inhibit, 1 clear, 2 write, 3 verify
  int unsigned m_cell [DEPTH];
  int          m_op = 0;
  int          m_addr = 0;
  int          m_ph = 0;
  int          m_lo = 255;
  int          quiet = 0;
  int          checks = 0;
  int          failures = 0;
  int          cycles = 0;
  bit          done = 0;

  function automatic int op_of(input logic [3:0] c);
    if (c == 4'b0101) return 1;
    if (c == 4'b1110) return 2;
    if (c == 4'b1100) return 3;
    return 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_fall(input int d);
    if (m_op == 1) return;
    if (m_ph == 1 && m_op == 2) m_lo = d;
    if (m_ph == 2) begin
      if (m_op == 2 && prog_en) m_cell[m_addr] = m_cell[m_addr] & ((d << 8) | m_lo);
      m_addr = (m_addr + 1) % DEPTH;
    end
    m_ph = (m_ph + 1) % 4;
  endtask

  task automatic set_mode(input logic [3:0] c);
    @(negedge clk);
    md = c; quiet = 0;
    m_op = op_of(c);
    if (m_op == 1) begin m_addr = 0; m_ph = 0; end
    repeat (8) @(negedge clk);
  endtask

  task automatic pulse(input logic [7:0] d);
    @(negedge clk);
    data_i = d; pclk = 1'b1; quiet = 0;
    repeat (3) @(negedge clk);
    pclk = 1'b0; quiet = 0;
    model_fall(int'(d));
    repeat (7) @(negedge clk);
  endtask

  task automatic write_word(input logic [15:0] w);
    pulse(8'h00);
    pulse(w[7:0]);
    pulse(w[15:8]);
    pulse(8'h00);
  endtask

  task automatic read_word(input string tag, input logic [15:0] w);
    chk({tag, " oe"}, int'(data_oe), 1);
    chk({tag, " low byte"}, int'(data_o), int'(w[7:0]));
    pulse(8'h00);
    pulse(8'h00);
    chk({tag, " high byte"}, int'(data_o), int'(w[15:8]));
    pulse(8'h00);
    pulse(8'h00);
  endtask

  // per-clock comparison against the model once the inputs have settled (R6, R7)
  always @(posedge clk) begin
    #1;
    cycles++;
    if (!rst && !done) begin
      quiet++;
      if (quiet >= 6) begin
        int exp_oe, exp_d;
        exp_oe = (m_op == 3) ? 1 : 0;
        exp_d  = 0;
        if (exp_oe == 1)
          exp_d = (m_ph == 2) ? int'((m_cell[m_addr] >> 8) & 255) : int'(m_cell[m_addr] & 255);
        chk("R7 R6 oe per clock", int'(data_oe), exp_oe);
        chk("R6 R7 byte per clock", int'(data_o), exp_d);
      end
    end
    if (cycles >= WDOG && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, WDOG);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) m_cell[i] = 32'hFFFF;
    repeat (5) @(negedge clk);
    chk("R1 oe in reset", int'(data_oe), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 oe after reset", int'(data_oe), 0);
    chk("R1 data after reset", int'(data_o), 0);

    // erased contents
    set_mode(4'b0101);
    set_mode(4'b1100);
    read_word("R10 erased word0", 16'hFFFF);
    read_word("R10 erased word1", 16'hFFFF);

    // programming four words
    prog_en = 1'b1;
    set_mode(4'b0101);
    set_mode(4'b1110);
    chk("R7 no drive in write", int'(data_oe), 0);
    write_word(16'hA55A);
    write_word(16'h1234);
    write_word(16'h00FF);
    write_word(16'h8001);
    set_mode(4'b0101);
    set_mode(4'b1100);
    read_word("R8 R4 word0", 16'hA55A);
    read_word("R8 R4 word1", 16'h1234);
    read_word("R8 R4 word2", 16'h00FF);
    read_word("R8 R4 word3", 16'h8001);

    // bits only fall; refused writes
    set_mode(4'b0101);
    set_mode(4'b1110);
    write_word(16'hF0FF);
    prog_en = 1'b0;
    write_word(16'h0000);
    prog_en = 1'b1;
    set_mode(4'b1111);
    write_word(16'h0000);
    set_mode(4'b0000);
    write_word(16'h0000);
    set_mode(4'b0101);
    set_mode(4'b1100);
    read_word("R8 and-merge word0", 16'hA05A);
    read_word("R9 unarmed word1", 16'h1234);
    read_word("R9 inhibit word2", 16'h00FF);
    read_word("R2 R9 undefined code word3", 16'h8001);

    // clear in mid-cycle, clock edges during clear ignored
    pulse(8'h00);
    set_mode(4'b0101);
    pulse(8'h00);
    pulse(8'h00);
    set_mode(4'b1100);
    read_word("R3 clear realigns", 16'hA05A);

    // wrap at the last address
    set_mode(4'b0101);
    set_mode(4'b1111);
    for (int c = 0; c < DEPTH - 1; c++) begin
      for (int p = 0; p < 4; p++) pulse(8'h00);
    end
    set_mode(4'b1110);
    write_word(16'h0F0F);
    set_mode(4'b1100);
    read_word("R5 wrap to word0", 16'hA05A);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule